// File: doc/BRIEF.md
# Beam-Synchronised Display List Coprocessor

This block walks a list of two-word instructions in memory and turns it into register writes that happen at chosen points of the raster beam. It has two instructions. One writes a 16-bit value into a register. The other stalls until the beam reaches a masked target position. The processor clock is the colour clock. The coprocessor may act only on even colour clocks, so one coprocessor cycle spans two colour clocks. It may also use the bus only in slots that the slot arbiter grants to it, and each instruction word fetch needs one granted slot.

The list address is a word counter. Reset clears it. A synchronous restart reloads it from a start-address input and drops any pending wait. The instruction memory is read combinationally: the word at `mem_addr` is taken in the granted slot where `mem_req` is high. A register write is presented on the port in the same colour clock as the second-word fetch of its instruction.

Top module: `dlist_coproc`

## Requirements
- R1: `mem_req` is raised only in colour clocks where `hpos[0]` is 0. Colour clocks with `hpos[0]` set never carry coprocessor activity.
- R2: A word is fetched only when `mem_req` and `slot_grant` are both high. In a requested slot without a grant, `mem_addr` holds, and the instruction stretches to the next even colour clock that is granted.
- R3: Each instruction is two 16-bit words, fetched first word then second word in separate coprocessor cycles. `mem_addr` advances by one after each fetched word.
- R4: A first word with bit 0 clear is a register write. `reg_we` pulses in the colour clock of the second-word fetch, with `reg_addr` equal to bits 8:1 of the first word and `reg_wdata` equal to the whole second word.
- R5: With every slot granted, back-to-back register-write instructions take two coprocessor cycles (four colour clocks) each.
- R6: A first word with bit 0 set is a wait. Its bits 15:8 hold the vertical target and bits 7:1 the horizontal target (compared with `hpos[7:1]`). Its second word holds the mask in bits 15:1, and bit 0 of the mask word is ignored. After the second fetch there is one wasted sleep-entry cycle, then a wakeup cycle, then the next first-word fetch. A wait that is already satisfied therefore costs exactly four coprocessor cycles (eight colour clocks).
- R7: The wait condition is `({vpos,hpos[7:1]} & mask) >= (target & mask)`, unsigned, so the vertical position dominates. While the condition is false, no fetch is requested. The first coprocessor cycle in which the condition holds is the wakeup cycle.
- R8: The sleep-entry and wakeup cycles need no slot grant and request no bus.
- R9: `restart`, sampled at a clock edge, sets `mem_addr` to `start_addr` and abandons any wait. A first-word fetch is requested on the next even colour clock.
- R10: While `rst_n` is low, `mem_addr` is 0 and `reg_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Active-low reset |
| restart | input | 1 | Synchronous reload of the list address |
| start_addr | input | AW | List address loaded on restart |
| slot_grant | input | 1 | Current bus slot is free for the coprocessor |
| vpos | input | VPOS_W | Beam vertical position |
| hpos | input | HPOS_W | Beam horizontal position in colour clocks |
| mem_req | output | 1 | Coprocessor wants to fetch a word in this slot |
| mem_addr | output | AW | Word address of the list |
| mem_rdata | input | VPOS_W+HPOS_W | Instruction word at mem_addr |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | RAW | Register address |
| reg_wdata | output | VPOS_W+HPOS_W | Register write data |

## Verification
A corrupted sequencer state or list address shows up at the ports within one coprocessor cycle. A write appears at the wrong beam position or with the wrong address or data, or `mem_addr` skips or holds in the wrong slot. A wrong wasted-cycle count or a wrong compare shifts every later write by whole multiples of two colour clocks, so the bench compares the exact vertical and horizontal position of each write and of selected fetches against a scoreboard. Lost grants and a restart that lands during a sleep are covered, so a miscounted stretch or a wait left pending after restart shifts or removes the writes that follow.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [1:0] {
        ST_FETCH1      = 2'd0,
        ST_FETCH2      = 2'd1,
        ST_SLEEP_ENTRY = 2'd2,
        ST_SLEEP       = 2'd3
    } dlc_state_e;

    function automatic logic dlc_is_bus_state(dlc_state_e s);
        return (s == ST_FETCH1) || (s == ST_FETCH2);
    endfunction
endpackage

// File: rtl/dlc_slot_gate.sv
module dlc_slot_gate (
    input  logic phase_bit,
    input  logic slot_grant,
    input  logic wants_bus,
    output logic cop_cycle,
    output logic bus_req,
    output logic fetch_go
);
    // even colour clocks belong to the coprocessor
    assign cop_cycle = ~phase_bit;
    assign bus_req   = cop_cycle & wants_bus;
    assign fetch_go  = bus_req & slot_grant;
endmodule

// File: rtl/dlc_beam_cmp.sv
module dlc_beam_cmp #(
    parameter int VPOS_W = 8,
    parameter int HPOS_W = 8,
    localparam int CMP_W = VPOS_W + HPOS_W - 1
) (
    input  logic [VPOS_W-1:0] vpos,
    input  logic [HPOS_W-2:0] hpos_hi,
    input  logic [CMP_W-1:0]  target,
    input  logic [CMP_W-1:0]  mask,
    output logic              reached
);
    logic [CMP_W-1:0] beam_m;
    logic [CMP_W-1:0] tgt_m;

    // vertical in the upper bits gives it priority in one unsigned compare
    assign beam_m  = {vpos, hpos_hi} & mask;
    assign tgt_m   = target & mask;
    assign reached = (beam_m >= tgt_m);
endmodule

// File: rtl/dlc_write_port.sv
module dlc_write_port #(
    parameter int IW  = 16,
    parameter int RAW = 8
) (
    input  logic           fetch_go,
    input  logic           in_second,
    input  logic           is_wait,
    input  logic [RAW-1:0] reg_field,
    input  logic [IW-1:0]  rdata,
    output logic           reg_we,
    output logic [RAW-1:0] reg_addr,
    output logic [IW-1:0]  reg_wdata
);
    assign reg_we    = fetch_go & in_second & ~is_wait;
    assign reg_addr  = reg_field;
    assign reg_wdata = rdata;
endmodule

// File: rtl/dlist_coproc.sv
module dlist_coproc #(
    parameter int AW     = 10,
    parameter int VPOS_W = 8,
    parameter int HPOS_W = 8,
    parameter int RAW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic [AW-1:0]            start_addr,
    input  logic                     slot_grant,
    input  logic [VPOS_W-1:0]        vpos,
    input  logic [HPOS_W-1:0]        hpos,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    input  logic [VPOS_W+HPOS_W-1:0] mem_rdata,
    output logic                     reg_we,
    output logic [RAW-1:0]           reg_addr,
    output logic [VPOS_W+HPOS_W-1:0] reg_wdata
);
    import dlc_pkg::*;

    localparam int IW    = VPOS_W + HPOS_W;
    localparam int CMP_W = IW - 1;

    typedef struct packed {
        dlc_state_e       st;
        logic [AW-1:0]    pc;
        logic [IW-1:0]    ir1;
        logic [CMP_W-1:0] mask;
    } dlc_regs_t;

    dlc_regs_t cur_q, nxt_d;

    logic cop_cycle;
    logic fetch_go;
    logic reached;

    dlc_slot_gate u_gate (
        .phase_bit (hpos[0]),
        .slot_grant(slot_grant),
        .wants_bus (dlc_is_bus_state(cur_q.st)),
        .cop_cycle (cop_cycle),
        .bus_req   (mem_req),
        .fetch_go  (fetch_go)
    );

    dlc_beam_cmp #(
        .VPOS_W(VPOS_W),
        .HPOS_W(HPOS_W)
    ) u_cmp (
        .vpos   (vpos),
        .hpos_hi(hpos[HPOS_W-1:1]),
        .target (cur_q.ir1[IW-1:1]),
        .mask   (cur_q.mask),
        .reached(reached)
    );

    dlc_write_port #(
        .IW (IW),
        .RAW(RAW)
    ) u_wr (
        .fetch_go (fetch_go),
        .in_second(cur_q.st == ST_FETCH2),
        .is_wait  (cur_q.ir1[0]),
        .reg_field(cur_q.ir1[RAW:1]),
        .rdata    (mem_rdata),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata)
    );

    assign mem_addr = cur_q.pc;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_FETCH1: begin
                if (fetch_go) begin
                    nxt_d.ir1 = mem_rdata;
                    nxt_d.pc  = cur_q.pc + AW'(1);
                    nxt_d.st  = ST_FETCH2;
                end
            end
            ST_FETCH2: begin
                if (fetch_go) begin
                    nxt_d.pc = cur_q.pc + AW'(1);
                    if (cur_q.ir1[0]) begin
                        nxt_d.mask = mem_rdata[IW-1:1];
                        nxt_d.st   = ST_SLEEP_ENTRY;
                    end else begin
                        nxt_d.st   = ST_FETCH1;
                    end
                end
            end
            ST_SLEEP_ENTRY: begin
                // wasted cycle, costs a coprocessor cycle but no bus slot
                if (cop_cycle) nxt_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                // the cycle that sees the match is the wakeup cycle
                if (cop_cycle && reached) nxt_d.st = ST_FETCH1;
            end
            default: nxt_d.st = ST_FETCH1;
        endcase
        if (restart) begin
            nxt_d.st = ST_FETCH1;
            nxt_d.pc = start_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_FETCH1;
            cur_q.pc   <= '0;
            cur_q.ir1  <= '0;
            cur_q.mask <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hpos_lsb,
    input logic          slot_grant,
    input logic          restart,
    input logic [AW-1:0] start_addr,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          reg_we
);
    // R1: requests only on even colour clocks
    p_req_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !hpos_lsb);

    // R2: without a granted fetch the address holds
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(mem_req && slot_grant)) |=> $stable(mem_addr));

    // R3: a granted fetch advances the address by one word
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && mem_req && slot_grant) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    // R4: a write rides on a granted fetch
    p_we_on_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (mem_req && slot_grant));

    // R5: writes are at least one coprocessor cycle apart
    p_we_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R9: restart loads the start address
    p_restart_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (mem_addr == $past(start_addr)));
endmodule

bind dlist_coproc dlc_checker #(.AW(AW)) u_dlc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hpos_lsb  (hpos[0]),
    .slot_grant(slot_grant),
    .restart   (restart),
    .start_addr(start_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we)
);

// File: tb/tb_dlist_coproc.sv
module tb_dlist_coproc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hpos = '0;
    logic [7:0]  vpos = '0;
    logic        restart;
    logic        slot_grant;
    logic [9:0]  start_addr;
    logic        mem_req;
    logic [9:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;

    int n_run = 0;
    int n_fail = 0;
    int wd = 0;
    logic timed_out = 1'b0;

    logic       lreq  [3][256];
    logic [9:0] laddr [3][256];

    always #2 clk = ~clk;

    always @(posedge clk) begin
        hpos <= hpos + 8'd1;
        if (hpos == 8'hFF) vpos <= vpos + 8'd1;
        wd <= wd + 1;
        if (wd > 5000) timed_out <= 1'b1;
    end

    assign start_addr = 10'd2;
    assign restart    = (vpos == 8'd2) && (hpos == 8'h10);
    assign slot_grant = !((vpos == 8'd2) && (hpos == 8'h12 || hpos == 8'h14 ||
                          hpos == 8'h1A || hpos == 8'h24 || hpos == 8'h26));

    function automatic logic [15:0] prog(input logic [9:0] a);
        case (a)
            10'd0:  return 16'h0121;  // wait v1 h(0x20)
            10'd1:  return 16'hFFFE;
            10'd2:  return 16'h0020;  // write reg 0x10
            10'd3:  return 16'hA001;
            10'd4:  return 16'h0022;  // reg 0x11
            10'd5:  return 16'hA002;
            10'd6:  return 16'h00FF;  // wait v0, h max: vertical dominates
            10'd7:  return 16'hFFFE;
            10'd8:  return 16'h0024;  // reg 0x12
            10'd9:  return 16'hA003;
            10'd10: return 16'h0141;  // wait v1 h(0x40)
            10'd11: return 16'hFFFE;
            10'd12: return 16'h0026;  // reg 0x13
            10'd13: return 16'hA004;
            10'd14: return 16'hFF61;  // wait h(0x60), vertical masked out
            10'd15: return 16'h00FF;  // mask bit 0 set and ignored
            10'd16: return 16'h0028;  // reg 0x14
            10'd17: return 16'hA005;
            default: return 16'hFFFF;
        endcase
    endfunction
    assign mem_rdata = prog(mem_addr);

    always @(negedge clk) begin
        if (vpos < 8'd3) begin
            lreq[vpos][hpos]  <= mem_req;
            laddr[vpos][hpos] <= mem_addr;
        end
    end

    dlist_coproc dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .start_addr(start_addr),
        .slot_grant(slot_grant), .vpos(vpos), .hpos(hpos),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_log(input int v, input int h, input logic req_exp,
                           input int addr_exp, input string req);
        chk(lreq[v][h] == req_exp, req, $sformatf("mem_req v%0d h%0h", v, h),
            int'(lreq[v][h]), int'(req_exp));
        if (addr_exp >= 0)
            chk(int'(laddr[v][h]) == addr_exp, req,
                $sformatf("mem_addr v%0d h%0h", v, h), int'(laddr[v][h]), addr_exp);
    endtask

    // {vpos, hpos, reg_addr, reg_wdata} of each expected write, in order
    localparam logic [39:0] EXP_T [10] = '{
        {8'd1, 8'h24, 8'h10, 16'hA001},
        {8'd1, 8'h28, 8'h11, 16'hA002},
        {8'd1, 8'h34, 8'h12, 16'hA003},
        {8'd1, 8'h44, 8'h13, 16'hA004},
        {8'd1, 8'h64, 8'h14, 16'hA005},
        {8'd2, 8'h18, 8'h10, 16'hA001},
        {8'd2, 8'h1E, 8'h11, 16'hA002},
        {8'd2, 8'h2A, 8'h12, 16'hA003},
        {8'd2, 8'h36, 8'h13, 16'hA004},
        {8'd2, 8'h64, 8'h14, 16'hA005}
    };

    initial begin
        do @(negedge clk); while (hpos != 8'h04);
        chk(mem_addr == 10'd0, "R10", "mem_addr in reset", int'(mem_addr), 0);
        chk(reg_we == 1'b0, "R10", "reg_we in reset", int'(reg_we), 0);
        do @(negedge clk); while (hpos != 8'h08);
        rst_n = 1'b1;

        // R4 R5 R6 R7 R9: position, address and data of every write
        for (int i = 0; i < 10; i++) begin
            do @(negedge clk); while (!reg_we && !timed_out);
            if (timed_out) break;
            chk({vpos, hpos} == EXP_T[i][39:24], "R4",
                $sformatf("write %0d beam pos", i), int'({vpos, hpos}), int'(EXP_T[i][39:24]));
            chk(reg_addr == EXP_T[i][23:16], "R4",
                $sformatf("write %0d reg_addr", i), int'(reg_addr), int'(EXP_T[i][23:16]));
            chk(reg_wdata == EXP_T[i][15:0], "R4",
                $sformatf("write %0d reg_wdata", i), int'(reg_wdata), int'(EXP_T[i][15:0]));
        end
        @(negedge clk);

        // fetch and idle positions on line 1, all slots granted
        chk_log(1, 8'h22, 1'b1, 2, "R3");
        chk_log(1, 8'h23, 1'b0, -1, "R1");
        chk_log(1, 8'h24, 1'b1, 3, "R3");
        chk_log(1, 8'h26, 1'b1, 4, "R5");
        chk_log(1, 8'h2E, 1'b0, -1, "R6");   // wasted sleep entry
        chk_log(1, 8'h30, 1'b0, -1, "R6");   // wakeup
        chk_log(1, 8'h32, 1'b1, 8, "R6");
        chk_log(1, 8'h3C, 1'b0, -1, "R7");   // still asleep
        chk_log(1, 8'h40, 1'b0, -1, "R7");   // wakeup at match
        chk_log(1, 8'h42, 1'b1, 12, "R7");
        chk_log(1, 8'h5E, 1'b0, -1, "R6");   // masked wait still asleep
        // line 2: restart during a sleep plus denied slots
        chk_log(2, 8'h11, 1'b0, 2, "R9");
        chk_log(2, 8'h12, 1'b1, 2, "R2");
        chk_log(2, 8'h14, 1'b1, 2, "R2");
        chk_log(2, 8'h16, 1'b1, 2, "R2");
        chk_log(2, 8'h18, 1'b1, 3, "R2");
        chk_log(2, 8'h24, 1'b0, -1, "R8");
        chk_log(2, 8'h26, 1'b0, -1, "R8");
        chk_log(2, 8'h28, 1'b1, 8, "R8");

        if (timed_out) begin
            n_run++;
            n_fail++;
            $display("FAIL R4 watchdog expired actual=%0d expected<=%0d", wd, 5000);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule